// File: doc/BRIEF.md
# Release-on-Acknowledge Interrupter with Timed Retrigger

This block carries one local interrupt request onto one of seven active-low backplane request lines. A programmable level picks the line, and a level of zero turns interrupts off. The local request is an asynchronous input. The block synchronizes it, and a rising edge makes the interrupt pending. While it is pending, the selected line is held low.

When an interrupt handler runs an acknowledge cycle for the driven level, and the daisy-chain token reaches this block, the block claims the cycle. It places the programmed 8-bit status/ID vector on its data output, pulses an acknowledge-done strobe and releases the line. Acknowledge cycles that do not belong to this block go out on the daisy-chain output. These are cycles for another level, cycles that arrive while nothing is pending, and cycles that arrive without the token.

After a claimed acknowledge, further requests are masked for a timeout. The timeout is given as a parameter in nanoseconds and is converted to clock cycles. The mask ends early if the local source drops. If the source is still high when the timeout runs out, the block raises the request again. An interrupt that the software acknowledged but never cleared is therefore not lost.

Top module: `irq_relay`

## Requirements
- R1: A rising edge of `src_irq_i`, seen after synchronization, with a non-zero level L drives `irq_n_o[L-1]` low. The other six lines stay high, and at most one line is ever low.
- R2: With `level_i` = 0, a rising edge of the source drives no line. Setting the level to 0 releases any driven line on the next clock.
- R3: An acknowledge is claimed when `ack_strobe_i`=1, `chain_in_i`=1 and `ack_level_i` equals the driven level. One clock later every line is high and `ack_done_o` is high for exactly one clock.
- R4: While a claimed acknowledge lasts, `vec_data_o` holds the value `vector_i` had at the claim. When no acknowledge is claimed, `vec_data_o` is 0.
- R5: An acknowledge with a different level, or with `chain_in_i`=0, is not claimed. The line stays low, and `chain_out_o` equals `ack_strobe_i & chain_in_i`.
- R6: An acknowledge that arrives while nothing is pending is passed on: `chain_out_o`=1 and `ack_done_o`=0.
- R7: After a claim, if the source drops, the mask ends. The next rising edge raises a new request before the timeout.
- R8: After a claim with the source held high, the lines stay high for the timeout of T = MASK_NS*1000/CLK_PERIOD_PS cycles. After that the current level's line is driven low again.
- R9: Changing `level_i` while a request is pending releases the old line. No line is driven again until the next rising edge of the source.
- R10: After reset every line is high, and `ack_done_o`, `vec_data_o` and `chain_out_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq_i | input | 1 | Local interrupt request (asynchronous, active high) |
| level_i | input | 3 | Request line select, 1..7; 0 disables |
| vector_i | input | 8 | Status/ID vector returned on acknowledge |
| ack_strobe_i | input | 1 | Acknowledge cycle in progress |
| ack_level_i | input | 3 | Level being acknowledged |
| chain_in_i | input | 1 | Daisy-chain token in |
| irq_n_o | output | 7 | Request lines, active low; bit i is line i+1 |
| vec_data_o | output | 8 | Vector, valid during a claimed acknowledge |
| ack_done_o | output | 1 | One-clock pulse when an acknowledge is claimed |
| chain_out_o | output | 1 | Daisy-chain token out |

## Verification
The hardest state to reach is the timed retrigger. It needs a claimed acknowledge followed by a source that stays high for the whole mask window. The bench reaches it by raising the source, acknowledging at the matching level and then simply never lowering the source. It samples the lines just before and just after the T-cycle boundary, with T shortened through the parameters. The early exit from the mask is driven in a second directed test: the source is pulsed low and high again well inside the window.

// File: rtl/irq_relay_pkg.sv
package irq_relay_pkg;
  localparam int NUM_LINES = 7;
  localparam int LVL_W     = 3;
  localparam int VEC_W     = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_MASK} irq_state_e;

  // Active-low drive pattern for a level; level 0 drives nothing.
  function automatic logic [NUM_LINES-1:0] line_drive_n(input logic [LVL_W-1:0] lvl);
    logic [NUM_LINES-1:0] pat;
    pat = '1;
    if (lvl != '0) pat[lvl-1] = 1'b0;
    return pat;
  endfunction

  // Mask window length in clock cycles, never below one.
  function automatic int mask_cycles(input longint period_ps, input longint hold_ns);
    longint c;
    c = (hold_ns * 1000) / period_ps;
    if (c < 1) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] pipe;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= 1'b0;
        else        pipe[g] <= (g == 0) ? async_i : pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= pipe[STAGES-1];
  end

  assign level_o = pipe[STAGES-1];
  assign rise_o  = pipe[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_mask_timer.sv
module irq_mask_timer #(
  parameter int CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] START = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load_i)                 cnt_q <= START;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/irq_ack_port.sv
module irq_ack_port
  import irq_relay_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             strobe_i,
  input  logic             chain_in_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic             claim_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             done_o,
  output logic             chain_out_o
);
  logic             claim_q;
  logic [VEC_W-1:0] vec_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      vec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (hit_i) begin
        claim_q <= 1'b1;
        vec_q   <= vector_i;
        done_q  <= 1'b1;
      end else if (!strobe_i) begin
        claim_q <= 1'b0;
        vec_q   <= '0;
      end
    end
  end

  assign claim_o     = claim_q;
  assign vec_o       = vec_q;
  assign done_o      = done_q;
  assign chain_out_o = strobe_i & chain_in_i & ~hit_i & ~claim_q;
endmodule

// File: rtl/irq_relay.sv
module irq_relay
  import irq_relay_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int MASK_NS       = 1000000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_irq_i,
  input  logic [LVL_W-1:0]     level_i,
  input  logic [VEC_W-1:0]     vector_i,
  input  logic                 ack_strobe_i,
  input  logic [LVL_W-1:0]     ack_level_i,
  input  logic                 chain_in_i,
  output logic [NUM_LINES-1:0] irq_n_o,
  output logic [VEC_W-1:0]     vec_data_o,
  output logic                 ack_done_o,
  output logic                 chain_out_o
);
  localparam int MASK_CYC = mask_cycles(longint'(CLK_PERIOD_PS), longint'(MASK_NS));

  irq_state_e       state_q;
  logic [LVL_W-1:0] line_q;
  logic             src_lvl, src_rise;
  logic             claimed, hit, expired;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_irq_i),
    .level_o(src_lvl), .rise_o(src_rise)
  );

  // A claim: pending, token present, level matches, not already claimed.
  assign hit = (state_q == ST_PEND) && ack_strobe_i && chain_in_i &&
               (ack_level_i == line_q) && !claimed;

  irq_mask_timer #(.CYCLES(MASK_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(hit),
    .run_i(state_q == ST_MASK), .expired_o(expired)
  );

  irq_ack_port u_ack (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .strobe_i(ack_strobe_i),
    .chain_in_i(chain_in_i), .vector_i(vector_i), .claim_o(claimed),
    .vec_o(vec_data_o), .done_o(ack_done_o), .chain_out_o(chain_out_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (src_rise && level_i != '0) begin
            state_q <= ST_PEND;
            line_q  <= level_i;
          end
        end
        ST_PEND: begin
          if (hit)                    state_q <= ST_MASK;
          else if (level_i != line_q) state_q <= ST_IDLE;
        end
        ST_MASK: begin
          if (!src_lvl) state_q <= ST_IDLE;
          else if (expired) begin
            if (level_i != '0) begin
              state_q <= ST_PEND;
              line_q  <= level_i;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign irq_n_o = (state_q == ST_PEND) ? line_drive_n(line_q) : '1;
endmodule

// File: rtl/irq_relay_checker.sv
module irq_relay_checker
  import irq_relay_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [LVL_W-1:0]     level_i,
  input logic [VEC_W-1:0]     vector_i,
  input logic                 ack_strobe_i,
  input logic                 chain_in_i,
  input logic [NUM_LINES-1:0] irq_n_o,
  input logic [VEC_W-1:0]     vec_data_o,
  input logic                 ack_done_o,
  input logic                 chain_out_o
);
  p_one_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~irq_n_o) <= 1);

  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == '0) |=> (&irq_n_o));

  p_done_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done_o |-> (&irq_n_o));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done_o |=> !ack_done_o);

  p_vec_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done_o |-> (vec_data_o == $past(vector_i)));

  p_vec_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ack_strobe_i) |-> (vec_data_o == '0));

  p_chain_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out_o |-> (chain_in_i && ack_strobe_i));

  p_chain_vs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done_o |-> !chain_out_o);
endmodule

bind irq_relay irq_relay_checker u_chk (
  .clk(clk), .rst_n(rst_n), .level_i(level_i), .vector_i(vector_i),
  .ack_strobe_i(ack_strobe_i), .chain_in_i(chain_in_i), .irq_n_o(irq_n_o),
  .vec_data_o(vec_data_o), .ack_done_o(ack_done_o), .chain_out_o(chain_out_o)
);

// File: tb/irq_relay_bench.sv
module irq_relay_bench;
  localparam int PERIOD_PS = 4000;
  localparam int MASK_NS   = 400;
  localparam int T         = MASK_NS * 1000 / PERIOD_PS;  // 100 cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src = 1'b0;
  logic [2:0] level = 3'd0;
  logic [7:0] vector = 8'd0;
  logic       strobe = 1'b0;
  logic [2:0] alvl = 3'd0;
  logic       cin = 1'b0;
  logic [6:0] irq_n;
  logic [7:0] vdata;
  logic       done, cout;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2ns clk = ~clk;

  irq_relay #(.CLK_PERIOD_PS(PERIOD_PS), .MASK_NS(MASK_NS)) u_irq_relay (
    .clk(clk), .rst_n(rst_n), .src_irq_i(src), .level_i(level),
    .vector_i(vector), .ack_strobe_i(strobe), .ack_level_i(alvl),
    .chain_in_i(cin), .irq_n_o(irq_n), .vec_data_o(vdata),
    .ack_done_o(done), .chain_out_o(cout)
  );

  typedef struct packed {
    logic [2:0] lvl;
    logic [7:0] vec;
    logic [2:0] ack;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{lvl: 3'd1, vec: 8'hA5, ack: 3'd1},
    '{lvl: 3'd7, vec: 8'h3C, ack: 3'd7},
    '{lvl: 3'd4, vec: 8'h81, ack: 3'd2},
    '{lvl: 3'd0, vec: 8'h55, ack: 3'd0},
    '{lvl: 3'd3, vec: 8'hFF, ack: 3'd3},
    '{lvl: 3'd6, vec: 8'h00, ack: 3'd5}
  };

  // Expected line pattern, built bit by bit from the level.
  function automatic logic [6:0] want_lines(input logic [2:0] l);
    logic [6:0] r;
    for (int i = 1; i <= 7; i++) r[i-1] = (l == 3'(i)) ? 1'b0 : 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Start an acknowledge at a negedge and sample one clock later.
  task automatic ack_begin(input logic [2:0] l, input logic token);
    alvl = l; cin = token; strobe = 1'b1;
    cyc(1);
  endtask

  task automatic ack_end();
    strobe = 1'b0; cin = 1'b0;
    cyc(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cyc(3);
    // R10: reset state
    chk("R10 lines", irq_n, 7'h7F);
    chk("R10 done", done, 0);
    chk("R10 vec", vdata, 0);
    chk("R10 chain", cout, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int r = 0; r < 6; r++) begin
      logic hitx;
      level = ROWS[r].lvl; vector = ROWS[r].vec; src = 1'b0;
      cyc(4);
      src = 1'b1;
      cyc(5);
      chk(ROWS[r].lvl == 0 ? "R2 no request" : "R1 line low", irq_n, want_lines(ROWS[r].lvl));
      hitx = (ROWS[r].lvl != 0) && (ROWS[r].ack == ROWS[r].lvl);
      ack_begin(ROWS[r].ack, 1'b1);
      chk("R3 done pulse", done, hitx);
      chk("R4 vector", vdata, hitx ? ROWS[r].vec : 8'h00);
      chk(ROWS[r].lvl == 0 ? "R6 passed on" : "R5 chain out", cout, !hitx);
      chk("R3 R5 lines after ack", irq_n, hitx ? 7'h7F : want_lines(ROWS[r].lvl));
      vector = ~ROWS[r].vec;
      cyc(1);
      chk("R3 single pulse", done, 0);
      chk("R4 vector held", vdata, hitx ? ROWS[r].vec : 8'h00);
      ack_end();
      chk("R4 vector cleared", vdata, 0);
      src = 1'b0;
      level = 3'd0;
      cyc(3);
      chk("R2 level zero releases", irq_n, 7'h7F);
    end

    // R5: matching level without token is not claimed
    level = 3'd1; src = 1'b1;
    cyc(5);
    ack_begin(3'd1, 1'b0);
    chk("R5 no token done", done, 0);
    chk("R5 no token chain", cout, 0);
    chk("R5 no token line", irq_n, 7'h7E);
    ack_end();
    ack_begin(3'd1, 1'b1);
    chk("R3 claim with token", done, 1);
    ack_end();

    // R7: source drop ends the mask early
    src = 1'b0; level = 3'd2;
    cyc(4);
    src = 1'b1;
    cyc(5);
    chk("R7 setup line", irq_n, 7'h7D);
    ack_begin(3'd2, 1'b1);
    ack_end();
    src = 1'b0;
    cyc(4);
    src = 1'b1;
    cyc(5);
    chk("R7 new request before timeout", irq_n, 7'h7D);
    ack_begin(3'd2, 1'b1);
    ack_end();

    // R8: held source retriggers after T cycles
    src = 1'b0; level = 3'd5;
    cyc(4);
    src = 1'b1;
    cyc(5);
    ack_begin(3'd5, 1'b1);          // now 1 cycle after the claim edge
    chk("R8 released", irq_n, 7'h7F);
    strobe = 1'b0; cin = 1'b0;
    cyc(T - 3);                     // T-2 cycles after the claim edge
    chk("R8 still masked", irq_n, 7'h7F);
    cyc(3);                         // T+1 cycles after the claim edge
    chk("R8 retriggered", irq_n, 7'h6F);
    ack_begin(3'd5, 1'b1);
    ack_end();

    // R9: level change while pending
    src = 1'b0; level = 3'd3;
    cyc(4);
    src = 1'b1;
    cyc(5);
    chk("R9 setup line", irq_n, 7'h7B);
    level = 3'd6;
    cyc(2);
    chk("R9 old line released", irq_n, 7'h7F);
    cyc(10);
    chk("R9 no request without edge", irq_n, 7'h7F);
    src = 1'b0;
    cyc(4);
    src = 1'b1;
    cyc(5);
    chk("R9 new level on next edge", irq_n, 7'h5F);
    ack_begin(3'd4, 1'b1);
    chk("R5 other level chain", cout, 1);
    ack_end();
    level = 3'd0;
    cyc(2);
    chk("R2 final release", irq_n, 7'h7F);

    finish_run();
  end
endmodule